// File: doc/BRIEF.md
# Overlay-Banked Control Register File

This block is the register file that a microcontroller sees when it controls a line transceiver over an 8-bit parallel port. The port has an active-low chip select, a read/write select, a 4-bit address and separate write and read data buses. A read drives the bus only while the port is selected for reading, and the output-enable flag stands for the tri-state control of a shared bidirectional bus. Writes are captured on the rising clock edge.

The address space has two banks. A basic bank fills all sixteen addresses. An overlay bank fills only some of them, and when it is selected it takes the place of the basic registers at those addresses. The bank-select register has no overlay copy, so it can be reached from either bank. Addresses with no overlay register fall through to the basic bank.

The block also produces the enable levels for two clock outputs, a 15.36 MHz clock and a buffered crystal clock. Both enables come up on after any reset. They can only be turned off through an overlay register. A legacy enable field in the basic bank is kept as reserved bits. A software reset, requested through a basic register bit, returns the whole block to its reset state.

Top module: `ctl_regbank`

## Requirements
- R1: After the synchronous active-low reset (`rst_n` low), every register reads 0x00, the basic bank is selected, and both `clk1536_en` and `xtal_buf_en` are 1.
- R2: `rdata_oe` is 1 only while `cs_n` is 0 and `rd_wr` is 1. While `rdata_oe` is 0, `rdata` is 0x00.
- R3: With the basic bank selected, a write to any address 0..15 is read back at that address. Bit 7 of address 0 and bits 2 and 1 of address 15 are the exceptions covered by R7 and R9.
- R4: Bit 0 of the register at address 10 selects the bank (1 = overlay). The register reads and writes identically in either bank, and a new value first steers the access in the next cycle.
- R5: The overlay bank has registers only at addresses 0..9, 12 and 13. While it is selected, those addresses read and write overlay storage and leave the basic contents unchanged. Those contents reappear when the basic bank is selected again.
- R6: While the overlay bank is selected, addresses 10, 11, 14 and 15 read and write the basic registers.
- R7: Bits 2 and 1 of basic address 15 are reserved. They always read 0, and writing 1 to them never changes either clock enable.
- R8: Bit 2 of overlay address 9 at 1 makes `clk1536_en` 0, and bit 1 at 1 makes `xtal_buf_en` 0. At 0 the matching enable is 1. The enables follow from the cycle after the write.
- R9: Writing 1 to bit 7 of basic address 0 requests a software reset. That bit reads 1 during the next cycle. At the following edge every register returns to its R1 state and the bit clears, and a write in that pending cycle is discarded.
- R10: A cycle with `cs_n` at 1, or with `rd_wr` at 1, changes no register and no clock enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Port chip select, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not driven |
| rdata_oe | output | 1 | Read bus output enable |
| clk1536_en | output | 1 | Enable for the 15.36 MHz clock output |
| xtal_buf_en | output | 1 | Enable for the buffered crystal clock output |

## Verification
The assertions assume that every input is stable across each rising edge and that `rst_n` is held low for at least one edge before the first access. The bench meets this by driving all inputs half a cycle away from the edge and by releasing reset only after several cycles. The clock-enable properties also assume that a write is a single one-cycle strobe, so that the cycle after it shows that write's effect and no other. The bench's write task releases chip select right after the capturing edge, so every write lasts exactly one edge.

// File: rtl/ctl_regbank_pkg.sv
// Package: constants and helpers shared by the banked register file.
// Assumes an 8-bit data path and a 16-entry address space.
package ctl_regbank_pkg;
    localparam int unsigned DW          = 8;
    localparam int unsigned AW          = 4;
    localparam int unsigned NREG        = 1 << AW;
    localparam logic [AW-1:0] BANK_ADDR  = AW'(10);
    localparam int unsigned   BANK_BIT   = 0;
    localparam logic [AW-1:0] SWRST_ADDR = AW'(0);
    localparam int unsigned   SWRST_BIT  = 7;
    localparam logic [AW-1:0] LEGACY_ADDR = AW'(15);
    localparam logic [AW-1:0] CLKDIS_ADDR = AW'(9);
    localparam int unsigned   DIS1536_BIT = 2;
    localparam int unsigned   DISXTAL_BIT = 1;
    // Overlay population: addresses 0..9, 12, 13.
    localparam logic [NREG-1:0] OVL_POP = 16'h33FF;
    localparam logic [NREG-1:0] ALL_POP = '1;

    // Bits of a basic register that hold storage (reserved/self-clearing bits masked off).
    function automatic logic [DW-1:0] basic_store_mask(input logic [AW-1:0] a);
        logic [DW-1:0] m;
        m = '1;
        if (a == SWRST_ADDR)  m[SWRST_BIT]   = 1'b0;
        if (a == LEGACY_ADDR) begin
            m[DIS1536_BIT] = 1'b0;
            m[DISXTAL_BIT] = 1'b0;
        end
        return m;
    endfunction
endpackage

// File: rtl/ctl_host_port.sv
// Host port decode: turns chip select and read/write into a write strobe
// and a read enable. Assumes both inputs are synchronous to the block clock.
module ctl_host_port (
    input  logic cs_n,
    input  logic rd_wr,
    output logic wr_stb,
    output logic rd_en
);
    // Qualify the access direction with the chip select.
    always_comb begin
        wr_stb = !cs_n && !rd_wr;
        rd_en  = !cs_n &&  rd_wr;
    end
endmodule

// File: rtl/ctl_reg_array.sv
// Register array: one flop word per populated address, zero elsewhere.
// A synchronous clear has priority over writes. Assumes at most one write per cycle.
module ctl_reg_array #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 8,
    parameter logic [(1<<AW)-1:0] POP = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q [1<<AW]
);
    localparam int unsigned NREG = 1 << AW;

    for (genvar i = 0; i < NREG; i++) begin : g_word
        localparam logic [AW-1:0] IDX = AW'(i);
        if (POP[i]) begin : g_pop
            // Hold one word; reset and clear to zero, load on an addressed write.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)             q[i] <= '0;
                else if (we && waddr == IDX)   q[i] <= wdata;
            end
        end else begin : g_hole
            assign q[i] = '0;
        end
    end
endmodule

// File: rtl/ctl_clk_enable.sv
// Clock-enable decode: each enable is the inverse of a disable bit in
// the overlay control word. Reset values come from that word clearing to zero.
module ctl_clk_enable #(
    parameter int unsigned DW     = 8,
    parameter int unsigned BIT_HI = 2,
    parameter int unsigned BIT_LO = 1
) (
    input  logic [DW-1:0] dis_word,
    output logic          clk1536_en,
    output logic          xtal_buf_en
);
    logic [DW-1:0] sel_mask;
    logic          unused_rest;

    // Map disable bits onto active-high enables; fold the other bits away.
    always_comb begin
        sel_mask         = '0;
        sel_mask[BIT_HI] = 1'b1;
        sel_mask[BIT_LO] = 1'b1;
        clk1536_en       = !dis_word[BIT_HI];
        xtal_buf_en      = !dis_word[BIT_LO];
        unused_rest      = ^(dis_word & ~sel_mask);
    end
endmodule

// File: rtl/ctl_regbank.sv
// Top: banked register file behind an 8-bit host port. Routes accesses to the
// basic or overlay array, performs the self-clearing software reset, and
// exposes two clock enables. Assumes inputs are stable around the clock edge.
module ctl_regbank
    import ctl_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe,
    output logic          clk1536_en,
    output logic          xtal_buf_en
);
    logic          wr_stb, rd_en;
    logic          ovl_sel, to_ovl;
    logic          basic_we, ovl_we;
    logic          sw_pend;
    logic [DW-1:0] basic_wd, rd_word;
    logic [DW-1:0] basic_q [NREG];
    logic [DW-1:0] ovl_q   [NREG];

    ctl_host_port u_port (
        .cs_n   (cs_n),
        .rd_wr  (rd_wr),
        .wr_stb (wr_stb),
        .rd_en  (rd_en)
    );

    // Steer the access to the overlay only where an overlay word exists.
    always_comb begin
        ovl_sel  = basic_q[BANK_ADDR][BANK_BIT];
        to_ovl   = ovl_sel && OVL_POP[addr];
        basic_we = wr_stb && !to_ovl;
        ovl_we   = wr_stb &&  to_ovl;
        basic_wd = wdata & basic_store_mask(addr);
    end

    // Software-reset request: set by the write, cleared one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_pend) sw_pend <= 1'b0;
        else                   sw_pend <= basic_we && (addr == SWRST_ADDR) && wdata[SWRST_BIT];
    end

    ctl_reg_array #(.AW(AW), .DW(DW), .POP(ALL_POP)) u_basic (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sw_pend),
        .we    (basic_we),
        .waddr (addr),
        .wdata (basic_wd),
        .q     (basic_q)
    );

    ctl_reg_array #(.AW(AW), .DW(DW), .POP(OVL_POP)) u_ovl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sw_pend),
        .we    (ovl_we),
        .waddr (addr),
        .wdata (wdata),
        .q     (ovl_q)
    );

    // Read mux: pick the bank, show the pending reset flag, gate by enable.
    always_comb begin
        rd_word = to_ovl ? ovl_q[addr] : basic_q[addr];
        if (!to_ovl && addr == SWRST_ADDR) rd_word[SWRST_BIT] = sw_pend;
        rdata_oe = rd_en;
        rdata    = rd_en ? rd_word : '0;
    end

    ctl_clk_enable #(.DW(DW), .BIT_HI(DIS1536_BIT), .BIT_LO(DISXTAL_BIT)) u_clk (
        .dis_word    (ovl_q[CLKDIS_ADDR]),
        .clk1536_en  (clk1536_en),
        .xtal_buf_en (xtal_buf_en)
    );
endmodule

// File: rtl/ctl_regbank_chk.sv
// Checker: temporal properties of the banked register file, bound to the top.
// Assumes single-cycle write strobes and inputs stable around the edge.
module ctl_regbank_chk
    import ctl_regbank_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_wr,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic          rdata_oe,
    input logic          clk1536_en,
    input logic          xtal_buf_en,
    input logic          ovl_sel,
    input logic          sw_pend
);
    logic rst_q;

    // Track the previous reset level to spot its release.
    always_ff @(posedge clk) rst_q <= rst_n;

    // R1: state seen at the first edge after reset release.
    always_ff @(posedge clk) begin
        if (rst_n && !rst_q)
            assert_reset_state_R1: assert (clk1536_en && xtal_buf_en && !ovl_sel);
    end

    assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> rdata == '0);

    assert_oe_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !rd_wr) |-> !rdata_oe);

    assert_legacy_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_wr && !sw_pend && addr == LEGACY_ADDR)
        |=> $stable({clk1536_en, xtal_buf_en}));

    assert_dis_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_wr && !sw_pend && ovl_sel && addr == CLKDIS_ADDR)
        |=> clk1536_en == !$past(wdata[DIS1536_BIT]));

    assert_dis_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_wr && !sw_pend && ovl_sel && addr == CLKDIS_ADDR)
        |=> xtal_buf_en == !$past(wdata[DISXTAL_BIT]));

    assert_swrst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_pend |=> (!sw_pend && !ovl_sel && clk1536_en && xtal_buf_en));

    assert_no_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_n || rd_wr) && !sw_pend) |=> $stable({ovl_sel, clk1536_en, xtal_buf_en}));
endmodule

bind ctl_regbank ctl_regbank_chk u_chk (.*);

// File: tb/ctl_regbank_bench.sv
// Bench: sweeps every address in both banks against an arithmetic model.
module ctl_regbank_bench;
    logic       clk = 1'b0;
    logic       rst_n, cs_n, rd_wr;
    logic [3:0] addr;
    logic [7:0] wdata, rdata;
    logic       rdata_oe, clk1536_en, xtal_buf_en;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;
    logic [7:0] mb [16];
    logic [7:0] mo [16];

    always #10 clk = ~clk;

    ctl_regbank u_ctl_regbank (.*);

    function automatic bit pop(int a);          // R5 population
        return (a <= 9) || a == 12 || a == 13;
    endfunction
    function automatic logic [7:0] smask(int a);  // R7, R9 masked bits
        if (a == 0)  return 8'h7F;
        if (a == 15) return 8'hF9;
        return 8'hFF;
    endfunction
    function automatic bit msel();
        return mb[10][0];
    endfunction
    function automatic logic [7:0] exp_rd(int a);
        return (msel() && pop(a)) ? mo[a] : mb[a];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin mb[i] = 8'h00; mo[i] = 8'h00; end
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_clk(string tag);
        @(negedge clk); #2;
        check(tag, {6'd0, clk1536_en, xtal_buf_en}, {6'd0, !mo[9][2], !mo[9][1]});
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_wr = 1'b0; addr = 4'(a); wdata = d;
        #2 check("R2 oe during write", {7'd0, rdata_oe}, 8'h00);
        @(posedge clk); #1;
        cs_n = 1'b1; rd_wr = 1'b1;
        if (msel() && pop(a)) mo[a] = d;
        else                  mb[a] = d & smask(a);
    endtask

    task automatic rd(int a, string tag);
        @(negedge clk);
        cs_n = 1'b0; rd_wr = 1'b1; addr = 4'(a);
        #2;
        check("R2 oe on read", {7'd0, rdata_oe}, 8'h01);
        check(tag, rdata, exp_rd(a));
        @(posedge clk); #1;
        cs_n = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; rd_wr = 1'b1; addr = '0; wdata = '0;
        model_reset();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state and R2 idle bus
        chk_clk("R1 clocks after reset");
        check("R2 idle oe", {7'd0, rdata_oe}, 8'h00);
        check("R2 idle rdata", rdata, 8'h00);
        for (int a = 0; a < 16; a++) rd(a, "R1 reset value");

        // R3 basic sweep (bank bit kept 0, reset bit kept 0)
        for (int a = 0; a < 16; a++) begin
            logic [7:0] d;
            d = 8'((a * 37 + 5) & 8'hFF);
            if (a == 10) d[0] = 1'b0;
            if (a == 0)  d[7] = 1'b0;
            wr(a, d);
        end
        for (int a = 0; a < 16; a++) rd(a, "R3 basic readback");
        chk_clk("R7 reserved bits leave clocks on");

        // R4 select overlay; R5/R6 overlay sweep
        wr(10, 8'hA5);
        rd(10, "R4 bank register in overlay");
        for (int a = 0; a < 16; a++) begin
            logic [7:0] d;
            d = 8'((a * 53 + 33) & 8'hFF);
            if (a == 10) d[0] = 1'b1;
            wr(a, d);
        end
        for (int a = 0; a < 16; a++) rd(a, pop(a) ? "R5 overlay readback" : "R6 fall-through readback");
        chk_clk("R8 clocks from overlay sweep");

        // R8 exhaustive disable bits
        for (int d = 0; d < 8; d++) begin
            wr(9, 8'(d));
            chk_clk("R8 disable bits");
        end

        // R4/R5 back to basic: basic contents preserved
        wr(10, 8'h00);
        for (int a = 0; a < 16; a++) rd(a, "R5 basic preserved");

        // R7 legacy bits with clocks off and on
        wr(15, 8'hFF);
        chk_clk("R7 legacy write with clocks off");
        rd(15, "R7 reserved bits read 0");
        wr(10, 8'h01); wr(9, 8'h00); wr(10, 8'h00);
        wr(15, 8'h06);
        chk_clk("R7 legacy write with clocks on");
        rd(15, "R7 reserved bits read 0");

        // R10 unselected writes and reads change nothing
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            cs_n = 1'b1; rd_wr = 1'b0; addr = 4'(a); wdata = 8'h81;
            @(negedge clk);
            cs_n = 1'b0; rd_wr = 1'b1;
        end
        @(negedge clk); cs_n = 1'b1;
        for (int a = 0; a < 16; a++) rd(a, "R10 no stray write");

        // R9 software reset from overlay state with clocks off
        wr(10, 8'h01); wr(9, 8'h06); wr(10, 8'h00);
        chk_clk("R8 clocks off before reset");
        wr(0, 8'h80);
        @(negedge clk);
        cs_n = 1'b0; rd_wr = 1'b1; addr = 4'd0;
        #2 check("R9 pending bit reads 1", rdata, 8'h80);
        @(posedge clk); #1 cs_n = 1'b1;
        model_reset();
        chk_clk("R9 clocks on after soft reset");
        for (int a = 0; a < 16; a++) rd(a, "R9 registers cleared");

        // R9 write during pending cycle is discarded
        wr(0, 8'h80);
        wr(3, 8'h55);
        model_reset();
        rd(3, "R9 write in pending cycle dropped");
        rd(0, "R9 request bit cleared");

        done = 1;
        summary();
        $finish;
    end
endmodule